// File: doc/BRIEF.md
# Trigger-Buffered Switch Control Register File

This block is the register file that sits behind a serial control slave in a front-end switch controller. It receives plain write and read strobes with a 5-bit address and 8-bit data. It keeps the switch selection register, the combined power-mode/trigger register and a self-clearing software-reset bit. From the live switch selection it produces registered throw-enable outputs and a common-port-to-ground short output.

Triggerable registers have two stages. A write first lands in a pending (shadow) copy. The live copy changes only when the register's assigned trigger fires. A configuration parameter ties each triggerable register to one of three triggers. If that trigger is masked, the write passes straight through to the live copy. After reset the block sits in low-power mode, and in that mode every output is held off. Software must write the normal power mode before any throw can close.

Top module: `swctl_regfile`

## Requirements
- R1: After reset the power mode reads 2'b10 (low power). All three trigger masks are 0, the switch register (address 0x00) reads 0x00, and throw_en and gnd_short are 0.
- R2: While the power mode is anything other than 2'b00, throw_en and gnd_short are 0. The stored switch register value is kept and reads back unchanged.
- R3: When the switch register's trigger is unmasked, a write to address 0x00 changes neither its read-back value nor the outputs until that trigger fires.
- R4: Writing address 0x1C with bit k set (k = 0, 1, 2) fires trigger k. This copies the pending value into every register assigned to trigger k. Firing any other trigger has no effect on them.
- R5: When the mask bit of a register's trigger is set, a write to that register updates its live value at once. The mask for trigger k is bit 3+k of address 0x1C.
- R6: Reading address 0x1C returns the power mode in bits 7:6 and the masks in bits 5:3. The trigger bits 2:0 always read as 0.
- R7: In normal mode with bit 6 clear, throw_en[3:0] equals bits 3:0 of the live switch register. A value of 0 opens every throw (isolation).
- R8: In normal mode, bit 6 of the live switch register drives gnd_short to 1 and forces throw_en to 0, whatever the other bits hold.
- R9: A write to address 0x1A with bit 7 set returns every register to its reset value, including pending copies, masks and power mode. Reading address 0x1A returns 0x00.
- R10: A write to address 0x1C whose bits 7:6 equal 2'b01 restores all registers to their reset values. The power mode then reads 2'b10.
- R11: throw_en and gnd_short change on the clock edge after the edge that updates the live register or the power mode. rdata is loaded on the edge where rd_en is sampled high and holds otherwise. Unused addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| throw_en | output | NUM_THROWS | Per-throw connect enables |
| gnd_short | output | 1 | Common port shorted to ground |

## Verification
On every cycle the assertions check that a non-normal power mode leaves both outputs inactive the next cycle, and that the short and throw enables never both assert. They also check that an unmasked write leaves the live register untouched, that trigger bits read back as zero, and that rdata holds between reads. Some behaviours only the bench scenarios can show, because they depend on a sequence of writes. These are the shadow-then-fire ordering, the selectivity of each trigger index, and the restore of defaults by the software-reset bit and by the default power mode. The bench also shows the one-cycle output latency relative to the write.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 8;
  localparam int NUM_TRIG = 3;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'b00,
    PM_DEFAULT = 2'b01,
    PM_LOW     = 2'b10,
    PM_RSVD    = 2'b11
  } pm_mode_e;

  localparam logic [ADDR_W-1:0] ADDR_SWITCH = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 5'h1A;
  localparam logic [ADDR_W-1:0] ADDR_PMTRIG = 5'h1C;

  localparam int SOFT_RST_BIT = 7;
  localparam int SHORT_BIT    = 6;
  localparam int MODE_LSB     = 6;
  localparam int MASK_LSB     = NUM_TRIG;
  localparam int FIRE_LSB     = 0;
endpackage

// File: rtl/swctl_pmtrig.sv
module swctl_pmtrig
  import swctl_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [1:0]          pm_mode,
  output logic [NUM_TRIG-1:0] trig_mask,
  output logic [NUM_TRIG-1:0] trig_fire,
  output logic                clr_all
);
  pm_mode_e mode_q;
  logic     pm_hit;
  logic     pm_default_wr;
  logic     soft_rst_wr;

  assign pm_hit        = wr_en && (addr == ADDR_PMTRIG);
  assign pm_default_wr = pm_hit && (pm_mode_e'(wdata[MODE_LSB +: 2]) == PM_DEFAULT);
  assign soft_rst_wr   = wr_en && (addr == ADDR_STATUS) && wdata[SOFT_RST_BIT];
  assign clr_all       = pm_default_wr || soft_rst_wr;

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      mode_q    <= PM_LOW;
      trig_mask <= '0;
    end else if (pm_hit) begin
      mode_q    <= pm_mode_e'(wdata[MODE_LSB +: 2]);
      trig_mask <= wdata[MASK_LSB +: NUM_TRIG];
    end
  end

  always_comb begin
    trig_fire = '0;
    if (pm_hit && !pm_default_wr) trig_fire = wdata[FIRE_LSB +: NUM_TRIG];
  end

  assign pm_mode = mode_q;
endmodule

// File: rtl/swctl_shadow_bank.sv
module swctl_shadow_bank
  import swctl_pkg::*;
#(
  parameter int                    NUM_REGS = 1,
  parameter logic [2*NUM_REGS-1:0] TRIG_MAP = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NUM_TRIG-1:0]          trig_mask,
  input  logic [NUM_TRIG-1:0]          trig_fire,
  output logic [NUM_REGS*DATA_W-1:0]   act_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam int SEL = int'(TRIG_MAP[2*i +: 2]);
    if (SEL >= NUM_TRIG) begin : g_bad_sel
      $error("trigger index out of range");
    end
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] live_q;
    logic              hit;

    assign hit = wr_en && (int'(addr) == i);

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        shadow_q <= '0;
        live_q   <= '0;
      end else begin
        if (hit) shadow_q <= wdata;
        if (hit && trig_mask[SEL]) live_q <= wdata;
        else if (trig_fire[SEL])   live_q <= shadow_q;
      end
    end

    assign act_flat[i*DATA_W +: DATA_W] = live_q;
  end
endmodule

// File: rtl/swctl_out_decode.sv
module swctl_out_decode
  import swctl_pkg::*;
#(
  parameter int NUM_THROWS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_THROWS-1:0] throw_req,
  input  logic                  short_req,
  input  logic [1:0]            pm_mode,
  output logic [NUM_THROWS-1:0] throw_en,
  output logic                  gnd_short
);
  logic active;
  assign active = (pm_mode_e'(pm_mode) == PM_NORMAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      throw_en  <= '0;
      gnd_short <= 1'b0;
    end else begin
      throw_en  <= (active && !short_req) ? throw_req : '0;
      gnd_short <= active && short_req;
    end
  end
endmodule

// File: rtl/swctl_regfile.sv
module swctl_regfile
  import swctl_pkg::*;
#(
  parameter int                    NUM_THROWS = 4,
  parameter int                    NUM_REGS   = 1,
  parameter logic [2*NUM_REGS-1:0] TRIG_MAP   = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [4:0]            addr,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  output logic [NUM_THROWS-1:0] throw_en,
  output logic                  gnd_short
);
  localparam int SW_IDX = int'(ADDR_SWITCH);

  logic [1:0]                 pm_mode;
  logic [NUM_TRIG-1:0]        trig_mask;
  logic [NUM_TRIG-1:0]        trig_fire;
  logic                       clr_all;
  logic [NUM_REGS*DATA_W-1:0] act_flat;
  logic [DATA_W-1:0]          sw_live;
  logic [DATA_W-1:0]          rd_mux;

  swctl_pmtrig u_pmtrig (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pm_mode(pm_mode), .trig_mask(trig_mask), .trig_fire(trig_fire),
    .clr_all(clr_all)
  );

  swctl_shadow_bank #(.NUM_REGS(NUM_REGS), .TRIG_MAP(TRIG_MAP)) u_bank (
    .clk(clk), .rst(rst), .clr(clr_all), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .trig_mask(trig_mask), .trig_fire(trig_fire),
    .act_flat(act_flat)
  );

  assign sw_live = act_flat[SW_IDX*DATA_W +: DATA_W];

  swctl_out_decode #(.NUM_THROWS(NUM_THROWS)) u_dec (
    .clk(clk), .rst(rst),
    .throw_req(sw_live[NUM_THROWS-1:0]), .short_req(sw_live[SHORT_BIT]),
    .pm_mode(pm_mode), .throw_en(throw_en), .gnd_short(gnd_short)
  );

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_PMTRIG) rd_mux = {pm_mode, trig_mask, {NUM_TRIG{1'b0}}};
    for (int i = 0; i < NUM_REGS; i++) begin
      if (int'(addr) == i) rd_mux = act_flat[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/swctl_regfile_chk.sv
module swctl_regfile_chk #(
  parameter int NUM_THROWS = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [4:0]            addr,
  input logic [7:0]            rdata,
  input logic [NUM_THROWS-1:0] throw_en,
  input logic                  gnd_short,
  input logic [1:0]            pm_mode,
  input logic [2:0]            trig_mask,
  input logic [7:0]            sw_act
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pm_mode == 2'b10 && trig_mask == 3'b000 && sw_act == 8'h00));

  assert_lowpower_off_R2: assert property (@(posedge clk) disable iff (rst)
    (pm_mode != 2'b00) |=> (throw_en == '0 && !gnd_short));

  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 5'h00 && trig_mask == 3'b000) |=> $stable(sw_act));

  assert_trig_readzero_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 5'h1C) |=> (rdata[2:0] == 3'b000));

  assert_short_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (pm_mode == 2'b00 && sw_act[6]) |=> (gnd_short && throw_en == '0));

  assert_short_excl_R8: assert property (@(posedge clk) disable iff (rst)
    gnd_short |-> (throw_en == '0));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind swctl_regfile swctl_regfile_chk #(.NUM_THROWS(NUM_THROWS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .throw_en(throw_en), .gnd_short(gnd_short),
  .pm_mode(pm_mode), .trig_mask(trig_mask), .sw_act(act_flat[7:0])
);

// File: tb/swctl_regfile_test.sv
module swctl_regfile_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] throw_en;
  logic       gnd_short;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_mode = 2, m_mask = 0, m_shadow = 0, m_live = 0;
  int m_throw = 0, m_short = 0, m_rdata = 0;
  localparam int SEL = 0;

  swctl_regfile uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .throw_en(throw_en), .gnd_short(gnd_short)
  );

  always #5 clk = ~clk;

  function automatic void model_defaults();
    m_mode = 2; m_mask = 0; m_shadow = 0; m_live = 0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      model_defaults();
      m_throw = 0; m_short = 0; m_rdata = 0;
    end else begin
      int a, d, rv;
      a = int'(addr); d = int'(wdata);
      if (m_mode == 0 && (m_live & 64) == 0) m_throw = m_live & 15; else m_throw = 0;
      m_short = (m_mode == 0 && (m_live & 64) != 0) ? 1 : 0;
      if (rd_en) begin
        rv = 0;
        if (a == 0) rv = m_live;
        else if (a == 28) rv = (m_mode << 6) | (m_mask << 3);
        m_rdata = rv;
      end
      if (wr_en) begin
        if (a == 0) begin
          m_shadow = d;
          if (((m_mask >> SEL) & 1) != 0) m_live = d;
        end else if (a == 26) begin
          if ((d & 128) != 0) model_defaults();
        end else if (a == 28) begin
          if (((d >> 6) & 3) == 1) model_defaults();
          else begin
            m_mode = (d >> 6) & 3;
            m_mask = (d >> 3) & 7;
            if (((d >> SEL) & 1) != 0) m_live = m_shadow;
          end
        end
      end
    end
  end

  task automatic compare_model();
    n_cmp++;
    if (int'(rdata) != m_rdata || int'(throw_en) != m_throw || int'(gnd_short) != m_short) begin
      n_bad++;
      $display("FAIL %s model: rdata=%h/%h throw=%b/%0h short=%b/%0d (actual/expected)",
               cur_req, rdata, m_rdata, throw_en, m_throw, gnd_short, m_short);
    end
  endtask

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare_model();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R1", int'(throw_en), 0);
    check("R1", int'(gnd_short), 0);
    rd(5'h1C); check("R1", int'(rdata), 8'h80);
    rd(5'h00); check("R1", int'(rdata), 8'h00);

    // R2 low power blocks outputs, value kept
    cur_req = "R2";
    wr(5'h00, 8'h05);
    wr(5'h1C, 8'h81);
    idle(2);
    check("R2", int'(throw_en), 0);
    rd(5'h00); check("R2", int'(rdata), 8'h05);
    wr(5'h1C, 8'hC0);
    idle(2);
    check("R2", int'(throw_en), 0);

    // R7 normal mode decode, R11 latency
    cur_req = "R7";
    wr(5'h1C, 8'h00);
    check("R11", int'(throw_en), 0);
    tick();
    check("R7", int'(throw_en), 4'b0101);

    // R3 unmasked write only reaches shadow
    cur_req = "R3";
    wr(5'h00, 8'h0A);
    idle(2);
    check("R3", int'(throw_en), 4'b0101);
    rd(5'h00); check("R3", int'(rdata), 8'h05);

    // R4 trigger selectivity
    cur_req = "R4";
    wr(5'h1C, 8'h06);
    idle(2);
    check("R4", int'(throw_en), 4'b0101);
    wr(5'h1C, 8'h01);
    idle(2);
    check("R4", int'(throw_en), 4'b1010);

    // R6 readback of mode/masks, trigger bits zero
    cur_req = "R6";
    rd(5'h1C); check("R6", int'(rdata), 8'h00);

    // R5 masked trigger: direct write
    cur_req = "R5";
    wr(5'h1C, 8'h08);
    wr(5'h00, 8'h0F);
    check("R11", int'(throw_en), 4'b1010);
    tick();
    check("R5", int'(throw_en), 4'b1111);
    rd(5'h1C); check("R6", int'(rdata), 8'h08);

    // R8 ground short override
    cur_req = "R8";
    wr(5'h00, 8'h4F);
    idle(2);
    check("R8", int'(gnd_short), 1);
    check("R8", int'(throw_en), 0);

    // R7 isolation
    cur_req = "R7";
    wr(5'h00, 8'h00);
    idle(2);
    check("R7", int'(throw_en), 0);
    check("R7", int'(gnd_short), 0);
    wr(5'h00, 8'h03);
    idle(2);
    check("R7", int'(throw_en), 4'b0011);

    // R9 software reset
    cur_req = "R9";
    wr(5'h1A, 8'h00);
    idle(2);
    check("R9", int'(throw_en), 4'b0011);
    wr(5'h1A, 8'h80);
    idle(2);
    check("R9", int'(throw_en), 0);
    rd(5'h1C); check("R9", int'(rdata), 8'h80);
    rd(5'h00); check("R9", int'(rdata), 8'h00);
    rd(5'h1A); check("R9", int'(rdata), 8'h00);

    // R10 default power mode restores defaults
    cur_req = "R10";
    wr(5'h1C, 8'h08);
    wr(5'h00, 8'h06);
    idle(2);
    check("R10", int'(throw_en), 4'b0110);
    wr(5'h1C, 8'h47);
    idle(2);
    check("R10", int'(throw_en), 0);
    rd(5'h1C); check("R10", int'(rdata), 8'h80);
    rd(5'h00); check("R10", int'(rdata), 8'h00);

    // R11 unused address and read hold
    cur_req = "R11";
    rd(5'h05); check("R11", int'(rdata), 8'h00);
    wr(5'h1C, 8'h18);
    rd(5'h1C); check("R11", int'(rdata), 8'h18);
    idle(3);
    check("R11", int'(rdata), 8'h18);

    finish_run();
  end
endmodule